// File: doc/BRIEF.md
# Serial Clock Divider with Settle Tracking

This block derives the serial clock of a quad-SPI host from a faster base clock. Software writes one control word. The word holds an enable bit and an 8-bit divider. The serial clock runs at the base rate divided by twice the effective divider. A read port returns the same word, and the read word also carries a hardware-owned stable flag.

A new divider does not take effect at the moment it is written. The block holds it as pending and switches to it only at the end of a complete output period, so the output never shows a shortened pulse. The stable flag drops as soon as a different divider is written. While the clock runs, the flag returns high once two full periods have been produced at the new rate. Software polls this flag before it starts a transfer. While the clock is disabled, the switch happens at once.

Top module: `sqclk_divider`

## Requirements
- R1: With the enable bit set and effective divider d, sclk repeats with a period of 2*d base cycles. Each period is d cycles low followed by d cycles high, and the first period after enabling starts with the low half.
- R2: The divider field occupies bits 15:8 of the control word. The read word returns the last written divider unchanged, including the value zero.
- R3: A changed divider takes effect only at the falling edge that ends a full period. Every high half therefore has the same length as the low half just before it.
- R4: The enable bit is bit 0 of the control word. Once a write clears it, sclk is low from the second sample after the write and stays low.
- R5: Bit 1 of the read word is the stable flag. It reads 0 from the first sample after a write whose divider differs from the held value. A write that carries the held divider leaves the flag unchanged, and bit 1 of any written word has no effect.
- R6: While enabled, the stable flag rises at the second period end after the new divider was applied.
- R7: While disabled, a changed divider is applied one cycle after the write, and the stable flag reads 1 again from the second sample after the write.
- R8: A divider of zero behaves as a divider of one, so sclk runs at half the base rate.
- R9: After reset the read word is 0x0102 (divider 1, clock disabled, stable high) and sclk is low.
- R10: Read-word bits 7:2 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Control word read-back with stable flag |
| sclk | output | 1 | Divided serial clock |

## Verification
A corrupted half-period counter or phase bit shows up at once on sclk as an uneven high or low run. The bench catches this on the next falling edge, because it compares every high run with the low run that came before it. An applied divider that is out of step with the held one shows up as a wrong period within one output period. A wrong pending or settle state shows up at bit 1 of the read word, either too early or too late. The reference model compares that bit on every cycle, so a premature rise or a missing fall is reported in the cycle it happens.

// File: rtl/sqclk_pkg.sv
package sqclk_pkg;
  localparam int unsigned SQC_CTL_W   = 16;
  localparam int unsigned SQC_DIV_W   = 8;
  localparam int unsigned SQC_DIV_LSB = 8;
  localparam int unsigned SQC_EN_BIT  = 0;
  localparam int unsigned SQC_STB_BIT = 1;
  localparam int unsigned SQC_SETTLE  = 2;
endpackage

// File: rtl/sqclk_ctrl.sv
module sqclk_ctrl #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned SETTLE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_en_bit,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             period_end,
  output logic             en,
  output logic [DIV_W-1:0] div_req,
  output logic [DIV_W-1:0] div_act,
  output logic             stable
);
  localparam int unsigned SW = $clog2(SETTLE + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE - 1);

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] v);
    return (v == '0) ? DIV_W'(1) : v;
  endfunction

  logic          pend;
  logic [SW-1:0] settle;
  logic          apply_now;
  logic          div_change;

  assign apply_now  = pend && (!en || period_end);
  assign div_change = wr_en && (wr_div != div_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      div_req <= DIV_W'(1);
      div_act <= DIV_W'(1);
      pend    <= 1'b0;
      stable  <= 1'b1;
      settle  <= '0;
    end else begin
      if (apply_now) begin
        div_act <= eff_div(div_req);
        pend    <= 1'b0;
        settle  <= '0;
      end
      if (!en) begin
        stable <= 1'b1;
      end else if (period_end && !pend && !stable) begin
        if (settle == SETTLE_LAST) stable <= 1'b1;
        else                       settle <= settle + 1'b1;
      end
      if (wr_en) begin
        en <= wr_en_bit;
      end
      if (div_change) begin
        div_req <= wr_div;
        pend    <= 1'b1;
        stable  <= 1'b0;
        settle  <= '0;
      end
    end
  end

  AST_CLR_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    div_change |=> !stable); // R5
  AST_APPLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_act) |-> $past(!en || period_end)); // R3
  AST_DISABLED_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en) |=> stable); // R7
  AST_STABLE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stable) && $past(en)) |-> $past(period_end)); // R6
  AST_NONZERO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    div_act != '0); // R8
endmodule

// File: rtl/sqclk_gen.sv
module sqclk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_act,
  output logic             sclk,
  output logic             period_end
);
  function automatic logic last_tick(input logic [DIV_W-1:0] c,
                                     input logic [DIV_W-1:0] d);
    return c == (d - 1'b1);
  endfunction

  logic [DIV_W-1:0] cnt;
  logic             phase;
  logic             half_end;

  assign half_end   = en && last_tick(cnt, div_act);
  assign period_end = half_end && phase;
  assign sclk       = phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!en) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (half_end) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < div_act); // R1
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sclk); // R4
endmodule

// File: rtl/sqclk_divider.sv
module sqclk_divider
  import sqclk_pkg::*;
#(
  parameter int unsigned CTL_W   = SQC_CTL_W,
  parameter int unsigned DIV_W   = SQC_DIV_W,
  parameter int unsigned DIV_LSB = SQC_DIV_LSB,
  parameter int unsigned EN_BIT  = SQC_EN_BIT,
  parameter int unsigned STB_BIT = SQC_STB_BIT,
  parameter int unsigned SETTLE  = SQC_SETTLE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] rd_data,
  output logic             sclk
);
  localparam logic [CTL_W-1:0] USED_MASK =
    (CTL_W'((1 << DIV_W) - 1) << DIV_LSB) | (CTL_W'(1) << EN_BIT);

  logic             en;
  logic             stable;
  logic             period_end;
  logic [DIV_W-1:0] div_req;
  logic [DIV_W-1:0] div_act;
  logic             unused_bits;

  assign unused_bits = ^(wr_data & ~USED_MASK);

  sqclk_ctrl #(.DIV_W(DIV_W), .SETTLE(SETTLE)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_en_bit  (wr_data[EN_BIT]),
    .wr_div     (wr_data[DIV_LSB +: DIV_W]),
    .period_end (period_end),
    .en         (en),
    .div_req    (div_req),
    .div_act    (div_act),
    .stable     (stable)
  );

  sqclk_gen #(.DIV_W(DIV_W)) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .div_act    (div_act),
    .sclk       (sclk),
    .period_end (period_end)
  );

  always_comb begin
    rd_data                    = '0;
    rd_data[EN_BIT]            = en;
    rd_data[STB_BIT]           = stable;
    rd_data[DIV_LSB +: DIV_W]  = div_req;
  end
endmodule

// File: tb/sqclk_divider_test.sv
`timescale 1ns/1ps
module sqclk_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        sclk;

  sqclk_divider uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sclk(sclk)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string tag = "R9";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: position within the output period
  int m_en, m_req, m_act, m_pend, m_stb, m_settle, m_pos;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_req = 1; m_act = 1; m_pend = 0; m_stb = 1; m_settle = 0; m_pos = 0;
    end else begin
      int per_end, n_pos, wdiv;
      per_end = (m_en != 0) && (m_pos == 2 * m_act - 1);
      n_pos = (m_en == 0 || per_end) ? 0 : m_pos + 1;
      if (m_en == 0) begin
        if (m_pend != 0) begin m_act = (m_req == 0) ? 1 : m_req; m_pend = 0; m_settle = 0; end
        m_stb = 1;
      end else if (per_end) begin
        if (m_pend != 0) begin m_act = (m_req == 0) ? 1 : m_req; m_pend = 0; m_settle = 0; end
        else if (m_stb == 0) begin
          m_settle++;
          if (m_settle == 2) m_stb = 1;
        end
      end
      if (wr_en) begin
        wdiv = int'(wr_data[15:8]);
        m_en = int'(wr_data[0]);
        if (wdiv != m_req) begin m_req = wdiv; m_pend = 1; m_stb = 0; m_settle = 0; end
      end
      m_pos = n_pos;
    end
  end

  // per-cycle comparison and run-length monitor
  logic prev_s = 1'b0;
  int lo_len = 0, hi_len = 0, lo_saved = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_rd, exp_s;
      exp_s  = (m_pos >= m_act) ? 1 : 0;
      exp_rd = (m_req << 8) | (m_stb << 1) | m_en;
      chk(int'(sclk) == exp_s, {tag, " sclk"}, int'(sclk), exp_s);
      chk(int'(rd_data) == exp_rd, {tag, " rd_data"}, int'(rd_data), exp_rd);
      if (!rd_data[0]) begin
        lo_len = 0; hi_len = 0; lo_saved = 0;
      end else if (sclk) begin
        if (!prev_s) begin lo_saved = lo_len; hi_len = 1; end
        else hi_len++;
      end else begin
        if (prev_s) begin
          if (lo_saved > 0) chk(hi_len == lo_saved, "R3 high run equals low run", hi_len, lo_saved);
          lo_len = 1;
        end else lo_len++;
      end
      prev_s = sclk;
    end
  end

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic period_of(output int p);
    logic pv;
    p = 0;
    pv = sclk;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (sclk && !pv) break;
      pv = sclk;
    end
    pv = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      p++;
      if (sclk && !pv) break;
      pv = sclk;
    end
  endtask

  task automatic wait_stable();
    for (int i = 0; i < 2000; i++) begin
      if (rd_data[1]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 16'h0102, "R9 reset word", int'(rd_data), 16'h0102);
    chk(sclk == 1'b0, "R9 reset sclk", int'(sclk), 0);
    chk(rd_data[7:2] == 6'd0, "R10 reserved bits", int'(rd_data[7:2]), 0);

    tag = "R1";
    wr(16'h0301);
    chk(rd_data[1] == 1'b0, "R5 stable clears on change", int'(rd_data[1]), 0);
    wait_stable();
    period_of(p);
    chk(p == 6, "R1 period div3", p, 6);

    tag = "R6";
    wr(16'h0501);
    wait_stable();
    period_of(p);
    chk(p == 10, "R6 period after settle div5", p, 10);

    tag = "R5";
    wr(16'h0503);
    chk(rd_data[1] == 1'b1, "R5 same divider keeps stable", int'(rd_data[1]), 1);
    chk(rd_data[15:8] == 8'd5, "R2 divider read-back", int'(rd_data[15:8]), 5);
    wr(16'h0703);
    chk(rd_data[1] == 1'b0, "R5 bit1 write ignored", int'(rd_data[1]), 0);
    wait_stable();

    tag = "R8";
    wr(16'h0001);
    chk(rd_data[15:8] == 8'd0, "R2 zero read-back", int'(rd_data[15:8]), 0);
    wait_stable();
    period_of(p);
    chk(p == 2, "R8 zero acts as one", p, 2);

    tag = "R7";
    wr(16'h0400);
    chk(rd_data[1] == 1'b0, "R7 stable low first sample", int'(rd_data[1]), 0);
    @(negedge clk);
    chk(rd_data[1] == 1'b1, "R7 stable high second sample", int'(rd_data[1]), 1);
    chk(sclk == 1'b0, "R4 idle after disable", int'(sclk), 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (sclk) chk(1'b0, "R4 held low", 1, 0);
    end
    wr(16'h0401);
    chk(rd_data[1] == 1'b1, "R7 stable kept on enable", int'(rd_data[1]), 1);
    period_of(p);
    chk(p == 8, "R1 period div4", p, 8);

    tag = "R3";
    repeat (3) @(negedge clk);
    wr(16'h0201);
    wr(16'h0601);
    wr(16'h0101);
    wait_stable();
    period_of(p);
    chk(p == 2, "R3 final divider in effect", p, 2);
    wr(16'h0301);
    repeat (5) @(negedge clk);
    wr(16'h0200);
    repeat (4) @(negedge clk);
    chk(sclk == 1'b0, "R4 disable mid-period", int'(sclk), 0);
    repeat (20) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule